// File: doc/BRIEF.md
# Bus cycle termination controller

This block ends each bus cycle that an external bus master interface opens. A request on `start_req` while the block is idle drives the active-low start strobe for one cycle. For a chip-select access, the block then counts a programmed number of wait states and drives the active-low acknowledge itself. For any other access, it waits for an acknowledge from outside. An optional bus monitor stops a cycle with an active-low error if no acknowledge has come within a programmed number of cycles. An error from outside also ends the cycle. This error input goes through a one-cycle register before the control logic uses it. The one exception is an error present in the strobe cycle, which is honoured at once.

Both the acknowledge and the error pins are shared, open-drain style. Each has its own output enable. The block enables a pin only in the cycle it asserts it and in the next cycle, in which it drives the negated level. It then releases the pin. For every access, a one-cycle `done` pulse with a `done_err` flag reports how the cycle ended.

The controller has six states:
- IDLE: nothing is driven.
- START: the strobe is driven.
- WAIT: wait states are counted, or the block waits for the outside acknowledge, the latched error or the monitor.
- ACK: the acknowledge is asserted.
- ERR: the error is asserted.
- NEGATE: the pin asserted in the previous cycle is driven to its negated level.

The transitions are:
- IDLE→START when `start_req` is high.
- START→ERR when the error input is low in that cycle.
- START→ACK for a chip-select access with zero wait states.
- START→WAIT for every other access.
- WAIT→ERR when the latched error is set or the monitor expires.
- WAIT→ACK on the last wait state.
- WAIT→IDLE when an outside acknowledge arrives.
- ACK→NEGATE and ERR→NEGATE.
- NEGATE→IDLE.

Top module: `bus_term_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ts_n`, `ack_n` and `err_n` are high and `ack_oe`, `err_oe`, `done` and `done_err` are low.
- R2: When `start_req` is high in an idle cycle, `ts_n` is low for exactly the next cycle, called cycle 0. A request made while an access is in progress is not taken until the block is idle again. With `start_req` held high on chip-select accesses of W wait states, a strobe appears every W+4 cycles.
- R3: For a chip-select access (`cs_access`=1) with wait count W (4 bits, taken when the request is accepted) that no error ends, `ack_n` is low with `ack_oe` high in cycle W+1 only.
- R4: After each cycle with `ack_n` low, `ack_oe` stays high with `ack_n` high for one cycle, and is low in the cycle after that.
- R5: After each cycle with `err_n` low, `err_oe` stays high with `err_n` high for one cycle, and is low in the cycle after that.
- R6: With `mon_en`=1 and limit L (8 bits), let M be the larger of L and 1. If the access has not been acknowledged and no error has ended it by cycle M, the error is asserted in cycle M+1. For a chip-select access this happens only when M < W. A final wait state falling in cycle M gives a normal acknowledge. The monitor count restarts with every access.
- R7: For an access that is not chip-select, `ext_ack_n` low in cycle a≥1 ends the access without error, with `done` high in cycle a+1. Neither output enable is raised.
- R8: Suppose `ext_err_n` is low in cycle c≥1 and the access has not ended by cycle c+1. Then the error is asserted in cycle c+2. For a chip-select access, c must be at most W-1 for this to take effect. An error at c=W or c=W+1 is ignored and the access is acknowledged in cycle W+1. A latched error wins over an outside acknowledge in the same cycle.
- R9: If `ext_err_n` is low in cycle 0, the error is asserted in cycle 1 for any access type and wait count, including W=0.
- R10: `done` is high for exactly one cycle per access. It is high in the cycle the acknowledge or error is asserted, or in cycle a+1 for an outside acknowledge. `done_err` is high with it only for an error ending. The two output enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Request to open a bus cycle |
| cs_access | input | 1 | 1: chip-select access, the block acknowledges itself |
| wait_states | input | 4 | Wait count W for chip-select accesses |
| mon_en | input | 1 | Bus monitor enable |
| mon_limit | input | 8 | Bus monitor limit L |
| ext_ack_n | input | 1 | Acknowledge from outside, active low |
| ext_err_n | input | 1 | Error from outside, active low |
| ts_n | output | 1 | Start strobe, active low |
| ack_n | output | 1 | Acknowledge level, active low |
| ack_oe | output | 1 | Acknowledge output enable |
| err_n | output | 1 | Error level, active low |
| err_oe | output | 1 | Error output enable |
| done | output | 1 | One-cycle pulse at the end of each access |
| done_err | output | 1 | Set with `done` when the access ended in error |

## Verification
The properties assume that `ext_err_n` and `ext_ack_n` always carry known levels. They also assume that a strobe with a low error input leads to an error in the next cycle, which holds only if nothing else can end the access sooner. The stimulus keeps to these assumptions. It drives every input on the falling edge. It pulses the outside acknowledge and the error for single cycles placed relative to the strobe. It leaves idle cycles between accesses so that no latched error carries over.

// File: rtl/bterm_pkg.sv
package bterm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_ACK    = 3'd3,
        ST_NEGATE = 3'd4,
        ST_ERR    = 3'd5
    } bterm_state_e;
endpackage

// File: rtl/bterm_err_latch.sv
module bterm_err_latch #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_raw,
    output logic err_lat
);
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= err_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[DEPTH-2:0], err_raw};
            end
        end
    endgenerate

    assign err_lat = stage_q[DEPTH-1];
endmodule

// File: rtl/bterm_wait_ctr.sv
module bterm_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              is_zero,
    output logic              is_last
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);
    assign is_last = (cnt_q <= WAIT_W'(1));
endmodule

// File: rtl/bterm_mon_timer.sv
module bterm_mon_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   tmr_q <= '0;
        else if (clr)                 tmr_q <= '0;
        else if (run && tmr_q != '1)  tmr_q <= tmr_q + 1'b1;
    end

    assign expired = (tmr_q >= limit);
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import bterm_pkg::*;
#(
    parameter int WAIT_W    = 4,
    parameter int TMO_W     = 8,
    parameter int ERR_DEPTH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cs_access,
    input  logic [WAIT_W-1:0] wait_states,
    input  logic              mon_en,
    input  logic [TMO_W-1:0]  mon_limit,
    input  logic              ext_ack_n,
    input  logic              ext_err_n,
    output logic              ts_n,
    output logic              ack_n,
    output logic              ack_oe,
    output logic              err_n,
    output logic              err_oe,
    output logic              done,
    output logic              done_err
);
    bterm_state_e state_q, state_d;

    logic             accept;
    logic             cs_q, mon_q, neg_err_q;
    logic [TMO_W-1:0] lim_q;
    logic             err_lat, w_zero, w_last, tmo_hit;
    logic             done_q, done_err_q;
    logic             ext_done;

    assign accept = (state_q == ST_IDLE) && start_req;

    bterm_err_latch #(.DEPTH(ERR_DEPTH)) u_err_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_raw (~ext_err_n),
        .err_lat (err_lat)
    );

    bterm_wait_ctr #(.WAIT_W(WAIT_W)) u_wait_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_states),
        .dec      (state_q == ST_WAIT),
        .is_zero  (w_zero),
        .is_last  (w_last)
    );

    bterm_mon_timer #(.TMO_W(TMO_W)) u_mon_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .run     ((state_q == ST_START) || (state_q == ST_WAIT)),
        .limit   (lim_q),
        .expired (tmo_hit)
    );

    // Access attributes captured when the request is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            mon_q <= 1'b0;
            lim_q <= '0;
        end else if (accept) begin
            cs_q  <= cs_access;
            mon_q <= mon_en;
            lim_q <= mon_limit;
        end
    end

    // Next-state selection; latched error outranks acknowledge, which outranks the monitor
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_START;
            ST_START: begin
                if (!ext_err_n)           state_d = ST_ERR;
                else if (cs_q && w_zero)  state_d = ST_ACK;
                else                      state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (err_lat)                  state_d = ST_ERR;
                else if (cs_q && w_last)      state_d = ST_ACK;
                else if (!cs_q && !ext_ack_n) state_d = ST_IDLE;
                else if (mon_q && tmo_hit)    state_d = ST_ERR;
                else                          state_d = ST_WAIT;
            end
            ST_ACK:    state_d = ST_NEGATE;
            ST_ERR:    state_d = ST_NEGATE;
            ST_NEGATE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign ext_done = (state_q == ST_WAIT) && (state_d == ST_IDLE);

    // State register and the registered completion report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            neg_err_q  <= 1'b0;
            done_q     <= 1'b0;
            done_err_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            done_q     <= (state_d == ST_ACK) || (state_d == ST_ERR) || ext_done;
            done_err_q <= (state_d == ST_ERR);
            if (state_d == ST_ERR)      neg_err_q <= 1'b1;
            else if (state_d == ST_ACK) neg_err_q <= 1'b0;
        end
    end

    // Pin levels and enables
    always_comb begin
        ts_n   = 1'b1;
        ack_n  = 1'b1;
        ack_oe = 1'b0;
        err_n  = 1'b1;
        err_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_START: ts_n = 1'b0;
            ST_WAIT:  ;
            ST_ACK: begin
                ack_n  = 1'b0;
                ack_oe = 1'b1;
            end
            ST_ERR: begin
                err_n  = 1'b0;
                err_oe = 1'b1;
            end
            ST_NEGATE: begin
                ack_oe = !neg_err_q;
                err_oe = neg_err_q;
            end
            default: ;
        endcase
    end

    assign done     = done_q;
    assign done_err = done_err_q;
endmodule

// File: rtl/bterm_chk.sv
module bterm_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_err_n,
    input logic ts_n,
    input logic ack_n,
    input logic ack_oe,
    input logic err_n,
    input logic err_oe,
    input logic done,
    input logic done_err
);
    AST_TS_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) !ts_n |=> ts_n); // R2
    AST_ACK_NEGATE:  assert property (@(posedge clk) disable iff (!rst_n) (ack_oe && !ack_n) |=> (ack_oe && ack_n)); // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (ack_oe && ack_n) |=> !ack_oe); // R4
    AST_ERR_NEGATE:  assert property (@(posedge clk) disable iff (!rst_n) (err_oe && !err_n) |=> (err_oe && err_n)); // R5
    AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (err_oe && err_n) |=> !err_oe); // R5
    AST_START_ERR:   assert property (@(posedge clk) disable iff (!rst_n) (!ts_n && !ext_err_n) |=> (err_oe && !err_n)); // R9
    AST_ACK_DONE:    assert property (@(posedge clk) disable iff (!rst_n) (ack_oe && !ack_n) |-> (done && !done_err)); // R10
    AST_ERR_DONE:    assert property (@(posedge clk) disable iff (!rst_n) (err_oe && !err_n) |-> (done && done_err)); // R10
    AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_FLAG_ALONE:  assert property (@(posedge clk) disable iff (!rst_n) done_err |-> done); // R10
    AST_OE_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(ack_oe && err_oe)); // R10
endmodule

bind bus_term_ctrl bterm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_err_n (ext_err_n),
    .ts_n      (ts_n),
    .ack_n     (ack_n),
    .ack_oe    (ack_oe),
    .err_n     (err_n),
    .err_oe    (err_oe),
    .done      (done),
    .done_err  (done_err)
);

// File: tb/sim_bus_term_ctrl.sv
module sim_bus_term_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       cs_access = 1'b0;
    logic [3:0] wait_states = '0;
    logic       mon_en = 1'b0;
    logic [7:0] mon_limit = '0;
    logic       ext_ack_n = 1'b1;
    logic       ext_err_n = 1'b1;
    logic       ts_n, ack_n, ack_oe, err_n, err_oe, done, done_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    bus_term_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cs_access(cs_access),
        .wait_states(wait_states), .mon_en(mon_en), .mon_limit(mon_limit),
        .ext_ack_n(ext_ack_n), .ext_err_n(ext_err_n), .ts_n(ts_n), .ack_n(ack_n),
        .ack_oe(ack_oe), .err_n(err_n), .err_oe(err_oe), .done(done), .done_err(done_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One access; kind 0 = own acknowledge, 1 = error, 2 = outside acknowledge
    task automatic run(input bit cs, input int w, input bit mon, input int lim,
                       input int err_at, input int ack_at);
        int kind, t, m, ek, ak, tk, leff;
        int first_ack, first_err, n_ack_oe, n_err_oe, n_done, done_c, n_derr, n_ts, neg_ok;
        string tag;
        leff = (lim < 1) ? 1 : lim;
        if (err_at == 0) begin
            kind = 1; t = 1; tag = "R9";
        end else if (cs) begin
            ek = (err_at >= 1 && err_at <= w - 1) ? err_at + 1 : 1000;
            tk = (mon && leff < w) ? leff : 1000;
            if (ek < 1000 && ek <= tk) begin kind = 1; t = ek + 1; tag = "R8"; end
            else if (tk < 1000)        begin kind = 1; t = tk + 1; tag = "R6"; end
            else                       begin kind = 0; t = w + 1;  tag = "R3"; end
        end else begin
            ek = (err_at >= 1) ? err_at + 1 : 1000;
            ak = (ack_at >= 1) ? ack_at : 1000;
            tk = mon ? leff : 1000;
            m = ek; if (ak < m) m = ak; if (tk < m) m = tk;
            if (ek == m)      begin kind = 1; t = ek + 1; tag = "R8"; end
            else if (ak == m) begin kind = 2; t = ak + 1; tag = "R7"; end
            else              begin kind = 1; t = tk + 1; tag = "R6"; end
        end
        first_ack = -1; first_err = -1; n_ack_oe = 0; n_err_oe = 0;
        n_done = 0; done_c = -1; n_derr = 0; n_ts = 0; neg_ok = 0;
        @(negedge clk);
        cs_access = cs; wait_states = 4'(w); mon_en = mon; mon_limit = 8'(lim); start_req = 1'b1;
        for (int c = 0; c <= t + 3; c++) begin
            @(negedge clk);
            if (c == 0) begin
                start_req = 1'b0;
                chk(ts_n == 1'b0, "R2", "strobe in cycle 0", int'(ts_n), 0);
            end else if (!ts_n) n_ts++;
            if (ack_oe) n_ack_oe++;
            if (err_oe) n_err_oe++;
            if (ack_oe && !ack_n && first_ack < 0) first_ack = c;
            if (err_oe && !err_n && first_err < 0) first_err = c;
            if (c == t + 1 && (ack_oe || err_oe) && ack_n && err_n) neg_ok = 1;
            if (done) begin n_done++; done_c = c; if (done_err) n_derr++; end
            ext_err_n = (c == err_at) ? 1'b0 : 1'b1;
            ext_ack_n = (c == ack_at) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        ext_err_n = 1'b1; ext_ack_n = 1'b1;
        chk(n_ts == 0, "R2", "no extra strobe", n_ts, 0);
        if (kind == 0) begin
            chk(first_ack == t, tag, "acknowledge cycle", first_ack, t);
            chk(first_err == -1 && n_err_oe == 0, tag, "no error drive", n_err_oe, 0);
            chk(n_ack_oe == 2 && neg_ok == 1, "R4", "acknowledge enable cycles", n_ack_oe, 2);
        end else if (kind == 1) begin
            chk(first_err == t, tag, "error cycle", first_err, t);
            chk(first_ack == -1 && n_ack_oe == 0, tag, "no acknowledge drive", n_ack_oe, 0);
            chk(n_err_oe == 2 && neg_ok == 1, "R5", "error enable cycles", n_err_oe, 2);
        end else begin
            chk(n_ack_oe == 0 && n_err_oe == 0, "R7", "no pin drive", n_ack_oe + n_err_oe, 0);
        end
        chk(n_done == 1 && done_c == t, "R10", "done cycle", done_c, t);
        chk(n_derr == ((kind == 1) ? 1 : 0), "R10", "done_err flag", n_derr, (kind == 1) ? 1 : 0);
        idle(2);
    endtask

    // Request held high: strobes must appear every w+4 cycles (R2)
    task automatic hold_run(input int w);
        int p, miss;
        p = w + 4; miss = 0;
        @(negedge clk);
        cs_access = 1'b1; wait_states = 4'(w); mon_en = 1'b0; start_req = 1'b1;
        for (int c = 0; c < 3 * p; c++) begin
            @(negedge clk);
            if ((ts_n == 1'b0) != ((c % p) == 0)) miss++;
            if (c == 3 * p - 1) start_req = 1'b0;
        end
        chk(miss == 0, "R2", "held request strobe spacing", miss, 0);
        idle(3);
    endtask

    initial begin
        idle(2);
        chk(ts_n && ack_n && err_n && !ack_oe && !err_oe && !done && !done_err,
            "R1", "outputs in reset", int'(ack_oe) + int'(err_oe) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ts_n && ack_n && err_n && !ack_oe && !err_oe && !done && !done_err,
            "R1", "outputs after reset", int'(ack_oe) + int'(err_oe) + int'(done), 0);

        // R3 R8 R9: chip-select sweep over wait count and error position
        for (int w = 0; w <= 7; w++)
            for (int e = -1; e <= w + 2; e++)
                run(1'b1, w, 1'b0, 0, e, -1);
        // R6: monitor against wait count
        for (int w = 0; w <= 7; w++)
            for (int l = 0; l <= 9; l++)
                run(1'b1, w, 1'b1, l, -1, -1);
        // R7 R8 R6: outside acknowledge against error and monitor
        for (int a = 1; a <= 7; a++)
            for (int e = -1; e <= 6; e++) begin
                run(1'b0, 0, 1'b1, 2, e, a);
                run(1'b0, 0, 1'b1, 6, e, a);
            end
        for (int a = 1; a <= 4; a++) run(1'b0, 0, 1'b0, 0, -1, a);
        for (int l = 0; l <= 5; l++) run(1'b0, 0, 1'b1, l, -1, -1);
        // Wide corners
        run(1'b1, 15, 1'b0, 0, 14, -1);
        run(1'b1, 15, 1'b0, 0, 15, -1);
        run(1'b1, 15, 1'b1, 14, -1, -1);
        run(1'b0, 0, 1'b1, 200, -1, -1);
        run(1'b0, 3, 1'b0, 0, 0, -1);
        // R2: hold-off while busy
        hold_run(0);
        hold_run(5);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule